// File: doc/BRIEF.md
# Dual-Buffer Flash Access Guard

This block decides, one request at a time, whether an operation may proceed on a serial flash array of 4096 pages of 264 bytes with two page buffers. A command decoder upstream hands it a request: program a page from a buffer, compare a page with a buffer, load a page into a buffer, read a buffer, or write a buffer. The guard answers each request one cycle later with either an accept pulse or an error pulse that carries a reason code.

Array operations (program, compare, load) are self-timed. The guard models each one as a busy period whose length is set per operation type by a parameter. While the period lasts, the active-low ready/busy output is driven low. During that time the array and the buffer that the operation uses are locked. The other buffer can still be read and written. A write-protect input shields the lowest 256 pages from programming. An active-low asynchronous reset abandons any operation in progress and keeps the guard idle for as long as it is held.

Top module: `flashGuard`

## Requirements
- R1: Operation codes on `reqOp` are 0 = program, 1 = compare, 2 = load page into buffer, 3 = buffer read, 4 = buffer write. When idle, a buffer read or write is answered by `accept` high for one cycle after the request edge, and `rdyBusyN` stays high.
- R2: While `wpN` is low, a program request to a page below 256 gets `errPulse` with `errCode` = 01 and no accept, and it starts no busy period.
- R3: While `wpN` is high, a program request to any page is accepted, including page 0. A program request to page 256 or above is accepted whatever the level of `wpN`.
- R4: An accepted program, compare or load drives `rdyBusyN` low from the request edge for N+1 clock cycles, where N is the parameter for that operation (`PROG_CYC`, `CMP_CYC`, `XFER_CYC`). A request sampled in the last of those cycles still counts as busy.
- R5: While busy, any program, compare or load request is rejected with `errCode` = 10.
- R6: While busy, a buffer read or write that names the engaged buffer is rejected with `errCode` = 10. One that names the other buffer is accepted.
- R7: Only one array operation is active at a time. `engagedBuf` takes the `reqBuf` value of the accepted array request and holds it until the next accepted array request.
- R8: `rstN` low at once forces `rdyBusyN` high, `accept` and `errPulse` low and `engagedBuf` to 0. Requests are ignored while it stays low. After release, an array request is accepted.
- R9: `accept` and `errPulse` are never high together, and each lasts one cycle per request. A protected program request reports 01 even while busy.
- R10: Codes 5 to 7 on `reqOp` produce neither accept nor error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Operation code (see R1) |
| reqPage | input | 12 | Target page address |
| reqBuf | input | 1 | Buffer number used by the request |
| wpN | input | 1 | Write protect, active low, shields pages 0 to 255 |
| accept | output | 1 | One-cycle pulse: request granted |
| errPulse | output | 1 | One-cycle pulse: request refused |
| errCode | output | 2 | Reason with errPulse: 01 protected, 10 busy conflict |
| rdyBusyN | output | 1 | Low while an array operation runs, high when released |
| engagedBuf | output | 1 | Buffer locked by the current or last array operation |

## Verification
Two things can fall in the same cycle: the busy count reaching its end and a new request arriving. The bench places a compare request exactly in the last busy cycle and expects a busy-conflict error. It then places a request one cycle later and expects it to be accepted. A second overlap is a protected program request arriving during a busy period. Both the protection rule and the busy rule apply to it, and the bench checks that the reason code reports protection.

// File: rtl/flashGuardPkg.sv
package flashGuardPkg;
  localparam logic [2:0] OP_PROG = 3'd0;
  localparam logic [2:0] OP_CMP  = 3'd1;
  localparam logic [2:0] OP_XFER = 3'd2;
  localparam logic [2:0] OP_BRD  = 3'd3;
  localparam logic [2:0] OP_BWR  = 3'd4;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_PROT = 2'b01;
  localparam logic [1:0] ERR_BUSY = 2'b10;

  // strobes from control to the busy datapath
  typedef struct packed {
    logic       start;   // launch an array operation
    logic [1:0] kind;    // 0 program, 1 compare, 2 load
    logic       bufSel;  // buffer engaged by it
  } strobeT;
endpackage

// File: rtl/flashGuardCtrl.sv
module flashGuardCtrl
  import flashGuardPkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PROT_PAGES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              reqBuf,
  input  logic              wpN,
  input  logic              busy,
  input  logic              engagedBuf,
  output strobeT            strobe,
  output logic              accept,
  output logic              errPulse,
  output logic [1:0]        errCode
);
  localparam logic [PAGE_W-1:0] PROT_LIMIT = PAGE_W'(PROT_PAGES);

  logic isArray, isBufOp, protHit, busyHit, grantNow, refuseNow;

  always_comb begin
    isArray   = (reqOp == OP_PROG) || (reqOp == OP_CMP) || (reqOp == OP_XFER);
    isBufOp   = (reqOp == OP_BRD) || (reqOp == OP_BWR);
    protHit   = (reqOp == OP_PROG) && !wpN && (reqPage < PROT_LIMIT);
    busyHit   = busy && (isArray || (isBufOp && (reqBuf == engagedBuf)));
    grantNow  = reqValid && (isArray || isBufOp) && !protHit && !busyHit;
    refuseNow = reqValid && (isArray || isBufOp) && (protHit || busyHit);
    strobe.start  = grantNow && isArray;
    strobe.kind   = reqOp[1:0];
    strobe.bufSel = reqBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept   <= 1'b0;
      errPulse <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      accept   <= grantNow;
      errPulse <= refuseNow;
      if (!refuseNow)   errCode <= ERR_NONE;
      else if (protHit) errCode <= ERR_PROT;
      else              errCode <= ERR_BUSY;
    end
  end

  // R2: protected program is refused with reason 01
  a_r2_protect: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_PROG && !wpN && reqPage < PROT_LIMIT)
      |=> (errPulse && errCode == ERR_PROT && !accept));
  // R5: array request while busy is refused with reason 10
  a_r5_busy_reject: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busy && (reqOp == OP_CMP || reqOp == OP_XFER))
      |=> (errPulse && errCode == ERR_BUSY));
  // R7: no launch while another operation runs
  a_r7_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> !busy);
  // R9: grant and refusal are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && errPulse));
endmodule

// File: rtl/flashGuardData.sv
module flashGuardData
  import flashGuardPkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int CMP_CYC  = 6,
  parameter int XFER_CYC = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobe,
  output logic   busy,
  output logic   engagedBuf
);
  localparam int MAX_A   = (PROG_CYC > CMP_CYC) ? PROG_CYC : CMP_CYC;
  localparam int MAX_CYC = (MAX_A > XFER_CYC) ? MAX_A : XFER_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remain, loadVal;

  always_comb begin
    case (strobe.kind)
      2'd0:    loadVal = CNT_W'(PROG_CYC);
      2'd1:    loadVal = CNT_W'(CMP_CYC);
      default: loadVal = CNT_W'(XFER_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      remain     <= '0;
      engagedBuf <= 1'b0;
    end else if (strobe.start) begin
      busy       <= 1'b1;
      remain     <= loadVal;
      engagedBuf <= strobe.bufSel;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // R4: a launch makes the array busy
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> busy);
  // R4: busy drops the cycle after the count is exhausted
  a_r4_drop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remain == '0) |=> !busy);
  // R7: engaged buffer is held during an operation
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.start) |=> $stable(engagedBuf));
endmodule

// File: rtl/flashGuard.sv
module flashGuard
  import flashGuardPkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PROT_PAGES = 256,
  parameter int PROG_CYC   = 20,
  parameter int CMP_CYC    = 6,
  parameter int XFER_CYC   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              reqBuf,
  input  logic              wpN,
  output logic              accept,
  output logic              errPulse,
  output logic [1:0]        errCode,
  output logic              rdyBusyN,
  output logic              engagedBuf
);
  strobeT strobe;
  logic   busy;

  flashGuardCtrl #(.PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqPage(reqPage), .reqBuf(reqBuf), .wpN(wpN), .busy(busy),
    .engagedBuf(engagedBuf), .strobe(strobe), .accept(accept),
    .errPulse(errPulse), .errCode(errCode)
  );

  flashGuardData #(.PROG_CYC(PROG_CYC), .CMP_CYC(CMP_CYC), .XFER_CYC(XFER_CYC)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .engagedBuf(engagedBuf)
  );

  // released line reads high; driven low while busy
  assign rdyBusyN = ~busy;
endmodule

// File: tb/flashGuard_tb.sv
`timescale 1ns/1ps
module flashGuard_tb;
  localparam int PROG_CYC = 20;
  localparam int CMP_CYC  = 6;
  localparam int XFER_CYC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = 3'd0;
  logic [11:0] reqPage = 12'd0;
  logic reqBuf = 1'b0;
  logic wpN = 1'b1;
  logic accept, errPulse, rdyBusyN, engagedBuf;
  logic [1:0] errCode;

  int nChk = 0;
  int nBad = 0;
  logic gotAcc, gotErr;
  logic [1:0] gotCode;

  always #4 clk = ~clk;

  flashGuard #(.PROG_CYC(PROG_CYC), .CMP_CYC(CMP_CYC), .XFER_CYC(XFER_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPage(reqPage),
    .reqBuf(reqBuf), .wpN(wpN), .accept(accept), .errPulse(errPulse),
    .errCode(errCode), .rdyBusyN(rdyBusyN), .engagedBuf(engagedBuf)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic issue(input logic [2:0] op, input logic [11:0] pg, input logic b);
    reqValid = 1'b1; reqOp = op; reqPage = pg; reqBuf = b;
    @(negedge clk);
    gotAcc = accept; gotErr = errPulse; gotCode = errCode;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!rdyBusyN) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 reset rdyBusyN", rdyBusyN, 1);
    check("R8 reset accept", accept, 0);
    check("R8 reset errPulse", errPulse, 0);
    check("R8 reset engagedBuf", engagedBuf, 0);
  endtask

  task automatic t_bufIdle();
    issue(3'd3, 12'd0, 1'b0);
    check("R1 idle read accept", gotAcc, 1);
    check("R1 idle read no busy", rdyBusyN, 1);
    issue(3'd4, 12'd0, 1'b1);
    check("R1 idle write accept", gotAcc, 1);
    @(negedge clk);
    check("R9 accept one cycle", accept, 0);
  endtask

  task automatic t_protect();
    wpN = 1'b0;
    issue(3'd0, 12'd0, 1'b0);
    check("R2 page0 err", gotErr, 1);
    check("R2 page0 code", gotCode, 1);
    check("R2 page0 no accept", gotAcc, 0);
    check("R2 page0 no busy", rdyBusyN, 1);
    issue(3'd0, 12'd255, 1'b0);
    check("R2 page255 code", gotCode, 1);
    check("R2 page255 no busy", rdyBusyN, 1);
    issue(3'd0, 12'd256, 1'b1);
    check("R3 page256 wp low accept", gotAcc, 1);
    check("R7 engaged buf 1", engagedBuf, 1);
    waitIdle();
    wpN = 1'b1;
    issue(3'd0, 12'd0, 1'b0);
    check("R3 page0 wp high accept", gotAcc, 1);
    check("R7 engaged buf 0", engagedBuf, 0);
    waitIdle();
  endtask

  task automatic t_duration();
    int n = 0;
    issue(3'd2, 12'd77, 1'b1);
    check("R4 load accept", gotAcc, 1);
    while (!rdyBusyN) begin n++; @(negedge clk); end
    check("R4 load busy length", n, XFER_CYC + 1);
    n = 0;
    issue(3'd0, 12'd900, 1'b0);
    while (!rdyBusyN) begin n++; @(negedge clk); end
    check("R4 program busy length", n, PROG_CYC + 1);
  endtask

  task automatic t_conflicts();
    issue(3'd1, 12'd500, 1'b1);
    check("R4 compare accept", gotAcc, 1);
    check("R7 compare engaged", engagedBuf, 1);
    issue(3'd0, 12'd600, 1'b0);
    check("R5 program while busy code", gotCode, 2);
    check("R5 program while busy no accept", gotAcc, 0);
    issue(3'd2, 12'd600, 1'b0);
    check("R5 load while busy code", gotCode, 2);
    check("R7 engaged unchanged", engagedBuf, 1);
    issue(3'd3, 12'd0, 1'b1);
    check("R6 read engaged code", gotCode, 2);
    issue(3'd4, 12'd0, 1'b0);
    check("R6 write other accept", gotAcc, 1);
    check("R6 write other no err", gotErr, 0);
    waitIdle();
  endtask

  task automatic t_boundary();
    issue(3'd1, 12'd10, 1'b0);
    // now k=0 after the request edge; last busy sample at k=CMP_CYC
    repeat (CMP_CYC) @(negedge clk);
    issue(3'd1, 12'd11, 1'b1);
    check("R4 last busy cycle refused", gotErr, 1);
    check("R5 last busy cycle code", gotCode, 2);
    issue(3'd1, 12'd11, 1'b1);
    check("R4 first idle cycle accepted", gotAcc, 1);
    waitIdle();
  endtask

  task automatic t_priority();
    wpN = 1'b0;
    issue(3'd0, 12'd400, 1'b0);
    check("R3 page400 accept", gotAcc, 1);
    issue(3'd0, 12'd3, 1'b1);
    check("R9 protect over busy code", gotCode, 1);
    @(negedge clk);
    check("R9 err one cycle", errPulse, 0);
    wpN = 1'b1;
    waitIdle();
  endtask

  task automatic t_unknown();
    issue(3'd5, 12'd1, 1'b0);
    check("R10 op5 accept", gotAcc, 0);
    check("R10 op5 err", gotErr, 0);
    issue(3'd7, 12'd1, 1'b0);
    check("R10 op7 err", gotErr, 0);
    check("R10 op7 no busy", rdyBusyN, 1);
  endtask

  task automatic t_resetMid();
    issue(3'd0, 12'd700, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 busy before abort", rdyBusyN, 0);
    rstN = 1'b0;
    #1;
    check("R8 async abort rdyBusyN", rdyBusyN, 1);
    check("R8 abort engagedBuf", engagedBuf, 0);
    @(negedge clk);
    issue(3'd2, 12'd5, 1'b1);
    check("R8 ignored in reset", gotAcc, 0);
    check("R8 held idle", rdyBusyN, 1);
    rstN = 1'b1;
    @(negedge clk);
    issue(3'd2, 12'd5, 1'b1);
    check("R8 accept after release", gotAcc, 1);
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_bufIdle();
    t_protect();
    t_duration();
    t_conflicts();
    t_boundary();
    t_priority();
    t_unknown();
    t_resetMid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule